// File: doc/BRIEF.md
# Test Access Port with Bus-Transaction Registers

This block is a 1149.1-style test access port that lets an external debug probe set up single-beat bus transactions. A 16-state controller follows the TMS line on rising TCK edges. A 4-bit instruction register selects one of several data registers, and every data register shares one shift path. The probe writes an address, write data, a reset-control word and a control word. The control word carries a direction bit, a size code and a start bit. Writing the start bit as 1 produces a one-cycle request pulse toward the core. Read data and a free-slot count come back from the core. The status of the last transaction is held as a snapshot, and that snapshot is refreshed only when an update completes with the status instruction selected.

Everything runs on TCK, and the core-side logic is assumed to share that clock. Both TRST_N low and five TCK cycles with TMS high put the block into reset: the instruction becomes the identification code and all configuration registers are cleared.

The controller states are TLR (test-logic reset), RTI (run/idle), SEL_DR, CAP_DR, SHIFT_DR, EXIT1_DR, PAUSE_DR, EXIT2_DR, UPD_DR, SEL_IR, CAP_IR, SHIFT_IR, EXIT1_IR, PAUSE_IR, EXIT2_IR and UPD_IR. Transitions, written as the state reached with TMS=0 and then with TMS=1:

- TLR: RTI, TLR
- RTI: RTI, SEL_DR
- SEL_DR: CAP_DR, SEL_IR
- SEL_IR: CAP_IR, TLR
- CAP_x: SHIFT_x, EXIT1_x
- SHIFT_x: SHIFT_x, EXIT1_x
- EXIT1_x: PAUSE_x, UPD_x
- PAUSE_x: PAUSE_x, EXIT2_x
- EXIT2_x: SHIFT_x, UPD_x
- UPD_x: RTI, SEL_DR

Top module: `jbt_top`

## Requirements
- R1: After any reset the instruction is the identification code 4'b1110. Its 32-bit register captures 32'hBADC0FFE.
- R2: Scanning the instruction register shifts out the capture value 4'b0001, LSB first. The new code takes effect on the rising edge that leaves UPD_IR.
- R3: Code 4'b1111 selects a 1-bit register that captures 0. TDO presents bit 0 of the selected register and changes on the falling TCK edge, so bypass delays TDI by one TCK cycle.
- R4: Code 4'b0001 selects the 32-bit address register. Its value drives bus_addr from the rising edge that leaves UPD_DR, and a capture reloads the current value, so a scan does not destroy it.
- R5: Code 4'b0010 selects the 64-bit write-data register, which drives bus_wdata. It captures its own contents on read-back.
- R6: Code 4'b0100 selects an 8-bit control register. Bit 7 is start, bit 6 is direction (1 = write), bits 5:3 are the read-only free-slot count, and bits 2:0 are the size code. On capture the start bit reads 0 and bits 5:3 read free_slots. An update with bit 7 set gives exactly one TCK cycle of bus_start; an update with bit 7 clear gives none.
- R7: Code 4'b0101 selects a status register of DATA_W+3 bits: txn_status in bits 2:0 and rd_data above them. Capture returns the snapshot taken at the latest update under this code (0 after reset). The register changes at no other time.
- R8: Code 4'b0011 selects a 64-bit read-only register that captures rd_data live. Bits shifted into it have no effect on any output.
- R9: Code 4'b1100 selects a 4-bit register whose updated value drives reset_ctl. It reads back non-destructively.
- R10: Five rising TCK edges with TMS high reach TLR from any state. In TLR, bus_addr, bus_wdata, bus_write, bus_size, reset_ctl, bus_start and the status snapshot clear to 0.
- R11: TRST_N low clears the same registers and the instruction asynchronously.
- R12: Codes 4'b0000, 4'b1010 and every unlisted code select the 1-bit bypass path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling tck |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Transaction write data |
| bus_write | output | 1 | Direction, 1 = write |
| bus_size | output | 3 | Transfer size code |
| bus_start | output | 1 | One-cycle transaction request |
| reset_ctl | output | RST_W | Programmable reset outputs |
| free_slots | input | 3 | Free slots reported by the core |
| txn_status | input | 3 | Status code of the latest transaction |
| rd_data | input | DATA_W | Read data returned by the core |

## Verification
The hardest behaviour to reach from the ports is the lag in the status snapshot. The first scan after selecting the status code must return the value frozen by an earlier update, not the inputs present now. To show this, the bench changes txn_status and rd_data between back-to-back status scans and expects each scan to return the previous scan's inputs. Reset through TMS alone is driven from run/idle as five high cycles. The model clears its registers on the first edge that finds the controller in TLR. Asynchronous TRST_N is asserted while the configuration registers hold non-zero values.

// File: rtl/jbt_pkg.sv
package jbt_pkg;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SHIFT_DR, EXIT1_DR, PAUSE_DR, EXIT2_DR, UPD_DR,
        SEL_IR, CAP_IR, SHIFT_IR, EXIT1_IR, PAUSE_IR, EXIT2_IR, UPD_IR
    } tap_state_e;

    localparam int IR_W = 4;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST = 4'b0000,
        OP_ADDR   = 4'b0001,
        OP_WDATA  = 4'b0010,
        OP_RDATA  = 4'b0011,
        OP_CTRL   = 4'b0100,
        OP_STATUS = 4'b0101,
        OP_SAMPLE = 4'b1010,
        OP_RSTCTL = 4'b1100,
        OP_IDCODE = 4'b1110,
        OP_BYPASS = 4'b1111
    } opcode_e;

    localparam logic [31:0]     ID_VALUE   = 32'hBADC0FFE;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
    localparam int              CTRL_W     = 8;

endpackage

// File: rtl/jbt_tap_fsm.sv
module jbt_tap_fsm
    import jbt_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e state_nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TLR;
        else         state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            TLR:      state_nxt = tms ? TLR      : RTI;
            RTI:      state_nxt = tms ? SEL_DR   : RTI;
            SEL_DR:   state_nxt = tms ? SEL_IR   : CAP_DR;
            CAP_DR:   state_nxt = tms ? EXIT1_DR : SHIFT_DR;
            SHIFT_DR: state_nxt = tms ? EXIT1_DR : SHIFT_DR;
            EXIT1_DR: state_nxt = tms ? UPD_DR   : PAUSE_DR;
            PAUSE_DR: state_nxt = tms ? EXIT2_DR : PAUSE_DR;
            EXIT2_DR: state_nxt = tms ? UPD_DR   : SHIFT_DR;
            UPD_DR:   state_nxt = tms ? SEL_DR   : RTI;
            SEL_IR:   state_nxt = tms ? TLR      : CAP_IR;
            CAP_IR:   state_nxt = tms ? EXIT1_IR : SHIFT_IR;
            SHIFT_IR: state_nxt = tms ? EXIT1_IR : SHIFT_IR;
            EXIT1_IR: state_nxt = tms ? UPD_IR   : PAUSE_IR;
            PAUSE_IR: state_nxt = tms ? EXIT2_IR : PAUSE_IR;
            EXIT2_IR: state_nxt = tms ? UPD_IR   : SHIFT_IR;
            UPD_IR:   state_nxt = tms ? SEL_DR   : RTI;
            default:  state_nxt = TLR;
        endcase
    end

    AST_SELIR_ESCAPE: assert property (@(posedge tck) disable iff (!trst_n)
        (state == SEL_IR && tms) |=> (state == TLR)); // R10

    AST_TLR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TLR && tms) |=> (state == TLR)); // R10

endmodule

// File: rtl/jbt_ir.sv
module jbt_ir
    import jbt_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state,
    output opcode_e    ir,
    output logic       ir_lsb
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr <= OP_IDCODE;
            ir    <= OP_IDCODE;
        end else begin
            unique case (state)
                TLR: begin
                    ir_sr <= OP_IDCODE;
                    ir    <= OP_IDCODE;
                end
                CAP_IR:   ir_sr <= IR_CAPTURE;
                SHIFT_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                UPD_IR:   ir    <= opcode_e'(ir_sr);
                default:  ;
            endcase
        end
    end

    assign ir_lsb = ir_sr[0];

    AST_IR_RESET_CODE: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TLR) |=> (ir == OP_IDCODE)); // R1

    AST_IR_ONLY_AT_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(ir) |-> ($past(state) == UPD_IR || $past(state) == TLR || state == TLR)); // R2

endmodule

// File: rtl/jbt_top.sv
module jbt_top
    import jbt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int RST_W  = 4
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_write,
    output logic [2:0]        bus_size,
    output logic              bus_start,
    output logic [RST_W-1:0]  reset_ctl,
    input  logic [2:0]        free_slots,
    input  logic [2:0]        txn_status,
    input  logic [DATA_W-1:0] rd_data
);

    localparam int STAT_W = DATA_W + 3;
    localparam int BIG_W  = (STAT_W > ADDR_W) ? STAT_W : ADDR_W;
    localparam int SR_W   = (BIG_W > 32) ? BIG_W : 32;
    localparam int SR_IW  = $clog2(SR_W);

    tap_state_e        state;
    opcode_e           ir;
    logic              ir_lsb;
    logic [SR_W-1:0]   sr, sr_nxt, cap_val;
    logic [SR_IW-1:0]  dr_msb;
    logic [STAT_W-1:0] status_q;

    jbt_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    jbt_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (state),
        .ir     (ir),
        .ir_lsb (ir_lsb)
    );

    // Length of the selected register and the value it captures
    always_comb begin
        cap_val = '0;
        dr_msb  = '0;
        case (ir)
            OP_IDCODE: begin cap_val[31:0]        = ID_VALUE;  dr_msb = SR_IW'(31);         end
            OP_ADDR:   begin cap_val[ADDR_W-1:0]  = bus_addr;  dr_msb = SR_IW'(ADDR_W-1);   end
            OP_WDATA:  begin cap_val[DATA_W-1:0]  = bus_wdata; dr_msb = SR_IW'(DATA_W-1);   end
            OP_RDATA:  begin cap_val[DATA_W-1:0]  = rd_data;   dr_msb = SR_IW'(DATA_W-1);   end
            OP_CTRL:   begin
                cap_val[CTRL_W-1:0] = {1'b0, bus_write, free_slots, bus_size};
                dr_msb = SR_IW'(CTRL_W-1);
            end
            OP_STATUS: begin cap_val[STAT_W-1:0]  = status_q;  dr_msb = SR_IW'(STAT_W-1);   end
            OP_RSTCTL: begin cap_val[RST_W-1:0]   = reset_ctl; dr_msb = SR_IW'(RST_W-1);    end
            default:   begin cap_val              = '0;        dr_msb = '0;                 end
        endcase
    end

    always_comb begin
        sr_nxt         = sr >> 1;
        sr_nxt[dr_msb] = tdi;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                sr <= '0;
        else if (state == CAP_DR)   sr <= cap_val;
        else if (state == SHIFT_DR) sr <= sr_nxt;
    end

    // Update stage: configuration, status snapshot and start request
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_write <= 1'b0;
            bus_size  <= '0;
            bus_start <= 1'b0;
            reset_ctl <= '0;
            status_q  <= '0;
        end else if (state == TLR) begin
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_write <= 1'b0;
            bus_size  <= '0;
            bus_start <= 1'b0;
            reset_ctl <= '0;
            status_q  <= '0;
        end else begin
            bus_start <= 1'b0;
            if (state == UPD_DR) begin
                case (ir)
                    OP_ADDR:   bus_addr  <= sr[ADDR_W-1:0];
                    OP_WDATA:  bus_wdata <= sr[DATA_W-1:0];
                    OP_CTRL: begin
                        bus_start <= sr[7];
                        bus_write <= sr[6];
                        bus_size  <= sr[2:0];
                    end
                    OP_STATUS: status_q  <= {rd_data, txn_status};
                    OP_RSTCTL: reset_ctl <= sr[RST_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                tdo <= 1'b0;
        else if (state == SHIFT_DR) tdo <= sr[0];
        else if (state == SHIFT_IR) tdo <= ir_lsb;
        else                        tdo <= 1'b0;
    end

    AST_START_SINGLE: assert property (@(posedge tck) disable iff (!trst_n)
        bus_start |=> !bus_start); // R6

    AST_TLR_CLEARS: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TLR) |=> (bus_addr == '0 && reset_ctl == '0 && !bus_start && status_q == '0)); // R10

    AST_ADDR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(bus_addr) |-> ($past(state) == UPD_DR || $past(state) == TLR || state == TLR)); // R4

    AST_STATUS_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(status_q) |-> ($past(state) == UPD_DR || $past(state) == TLR || state == TLR)); // R7

endmodule

// File: tb/jbt_top_tb.sv
module jbt_top_tb;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic [31:0] bus_addr;
    logic [63:0] bus_wdata;
    logic        bus_write;
    logic [2:0]  bus_size;
    logic        bus_start;
    logic [3:0]  reset_ctl;
    logic [2:0]  free_slots = 3'd5;
    logic [2:0]  txn_status = 3'd0;
    logic [63:0] rd_data = '0;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // behavioural model of the visible state
    logic [3:0]  m_ir = 4'b1110;
    logic [31:0] m_addr = '0;
    logic [63:0] m_wdata = '0;
    logic        m_write = 0;
    logic [2:0]  m_size = '0;
    logic        m_start = 0;
    logic [3:0]  m_rst = '0;
    logic [66:0] m_snap = '0;
    logic [127:0] last_din;
    logic [3:0]   last_ir;

    always #10 tck = ~tck;

    jbt_top u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_write(bus_write),
        .bus_size(bus_size), .bus_start(bus_start), .reset_ctl(reset_ctl),
        .free_slots(free_slots), .txn_status(txn_status), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int m_len(input logic [3:0] op);
        case (op)
            4'b1110: return 32;
            4'b0001: return 32;
            4'b0010: return 64;
            4'b0011: return 64;
            4'b0100: return 8;
            4'b0101: return 67;
            4'b1100: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [127:0] m_cap();
        logic [127:0] v = '0;
        case (m_ir)
            4'b1110: v[31:0] = 32'hBADC0FFE;
            4'b0001: v[31:0] = m_addr;
            4'b0010: v[63:0] = m_wdata;
            4'b0011: v[63:0] = rd_data;
            4'b0100: v[7:0]  = {1'b0, m_write, free_slots, m_size};
            4'b0101: v[66:0] = m_snap;
            4'b1100: v[3:0]  = m_rst;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [127:0] lowmask(input int n);
        return (n >= 128) ? '1 : ((128'd1 << n) - 128'd1);
    endfunction

    task automatic model_clear();
        m_ir = 4'b1110; m_addr = '0; m_wdata = '0; m_write = 0;
        m_size = '0; m_start = 0; m_rst = '0; m_snap = '0;
    endtask

    task automatic model_update();
        case (m_ir)
            4'b0001: m_addr  = last_din[31:0];
            4'b0010: m_wdata = last_din[63:0];
            4'b0100: begin m_start = last_din[7]; m_write = last_din[6]; m_size = last_din[2:0]; end
            4'b0101: m_snap  = {rd_data, txn_status};
            4'b1100: m_rst   = last_din[3:0];
            default: ;
        endcase
    endtask

    // kind: 0 none, 1 DR update edge, 2 TLR edge, 3 IR update edge
    task automatic step(input logic t, input logic d, input int kind, output logic o);
        @(negedge tck); #2;
        o = tdo;
        chk("R4 bus_addr", 128'(bus_addr), 128'(m_addr));
        chk("R5 bus_wdata", 128'(bus_wdata), 128'(m_wdata));
        chk("R6 bus_write", 128'(bus_write), 128'(m_write));
        chk("R6 bus_size", 128'(bus_size), 128'(m_size));
        chk("R6 bus_start", 128'(bus_start), 128'(m_start));
        chk("R9 reset_ctl", 128'(reset_ctl), 128'(m_rst));
        tms = t; tdi = d;
        @(posedge tck); #1;
        m_start = 0;
        if (kind == 1) model_update();
        if (kind == 2) model_clear();
        if (kind == 3) m_ir = last_ir;
    endtask

    task automatic scan_ir(input logic [3:0] code, input string tag);
        logic o;
        logic [3:0] got = '0;
        last_ir = code;
        step(1, 0, 0, o); step(1, 0, 0, o); step(0, 0, 0, o); step(0, 0, 0, o);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, code[i], 0, o);
            got[i] = o;
        end
        step(1, 0, 0, o);
        step(0, 0, 3, o);
        chk(tag, 128'(got), 128'(4'b0001));
    endtask

    task automatic scan_dr(input int n, input logic [127:0] din, input string tag);
        logic o;
        logic [127:0] got = '0;
        logic [127:0] exp;
        int L;
        L = m_len(m_ir);
        exp = m_cap();
        if (n > L) exp = (exp & lowmask(L)) | (din << L);
        exp = exp & lowmask(n);
        last_din = din;
        step(1, 0, 0, o); step(0, 0, 0, o); step(0, 0, 0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], 0, o);
            got[i] = o;
        end
        step(1, 0, 0, o);
        step(0, 0, 1, o);
        chk(tag, got, exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic o;
        // R11: outputs held at zero during TRST_N
        repeat (3) @(negedge tck);
        #2;
        chk("R11 addr in reset", 128'(bus_addr), 0);
        chk("R11 start in reset", 128'(bus_start), 0);
        chk("R11 rst in reset", 128'(reset_ctl), 0);
        tms = 0;
        trst_n = 1;
        step(0, 0, 0, o);

        scan_dr(32, '0, "R1 idcode after reset");
        scan_ir(4'b1111, "R2 ir capture");
        scan_dr(8, 128'hA5, "R3 bypass delay");

        scan_ir(4'b0001, "R2 ir capture");
        scan_dr(32, 128'h1234_5678, "R4 addr first read");
        scan_dr(32, 128'hDEAD_BEEF, "R4 addr readback");
        scan_dr(32, 128'hDEAD_BEEF, "R4 addr nondestructive");

        scan_ir(4'b0010, "R2 ir capture");
        scan_dr(64, 128'hFEDC_BA98_7654_3210, "R5 wdata write");
        scan_dr(64, 128'h0123_4567_89AB_CDEF, "R5 wdata readback");

        scan_ir(4'b0100, "R2 ir capture");
        scan_dr(8, 128'b1100_0011, "R6 ctrl start write");
        free_slots = 3'd2;
        scan_dr(8, 128'b0000_0101, "R6 ctrl readback no start");
        scan_dr(8, 128'b1000_0110, "R6 ctrl read start");

        rd_data = 64'hCAFE_0000_1111_2222;
        scan_ir(4'b0011, "R2 ir capture");
        scan_dr(64, 128'h5555, "R8 rdata live");
        rd_data = 64'h0F0F_F0F0_3C3C_C3C3;
        scan_dr(64, '1, "R8 rdata ignores shifted bits");

        txn_status = 3'd3;
        rd_data = 64'hAAAA_BBBB_CCCC_DDDD;
        scan_ir(4'b0101, "R2 ir capture");
        scan_dr(67, '0, "R7 status old snapshot");
        txn_status = 3'd5;
        rd_data = 64'h1;
        scan_dr(67, '0, "R7 status first snapshot");
        scan_dr(67, '0, "R7 status second snapshot");

        scan_ir(4'b1100, "R2 ir capture");
        scan_dr(4, 128'hA, "R9 reset ctl write");
        scan_dr(4, 128'h3, "R9 reset ctl readback");

        scan_ir(4'b0000, "R2 ir capture");
        scan_dr(8, 128'h3C, "R12 code 0000 bypass");
        scan_ir(4'b1010, "R2 ir capture");
        scan_dr(8, 128'hC3, "R12 code 1010 bypass");
        scan_ir(4'b0111, "R2 ir capture");
        scan_dr(8, 128'h96, "R12 unlisted bypass");

        // R10: five TMS-high cycles from run/idle
        step(1, 0, 0, o); step(1, 0, 0, o); step(1, 0, 0, o);
        step(1, 0, 2, o); step(1, 0, 2, o);
        step(0, 0, 2, o);
        chk("R10 addr cleared", 128'(bus_addr), 0);
        chk("R10 rst cleared", 128'(reset_ctl), 0);
        scan_dr(32, '0, "R10 ir back to idcode");
        scan_ir(4'b0101, "R2 ir capture");
        scan_dr(67, '0, "R10 status snapshot cleared");

        // R11: asynchronous reset with non-zero registers
        scan_ir(4'b0001, "R2 ir capture");
        scan_dr(32, 128'h0BAD_F00D, "R4 addr set");
        @(negedge tck); #2;
        trst_n = 0;
        #1;
        model_clear();
        chk("R11 async addr clear", 128'(bus_addr), 0);
        @(negedge tck); #2;
        tms = 0;
        trst_n = 1;
        step(0, 0, 0, o);
        scan_dr(32, '0, "R11 ir idcode after trst");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule